// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Clock Buffer

This block is a two-wire serial slave that holds seven 8-bit configuration bytes for a zero-delay clock buffer. A host writes the bytes with a block write and reads them back with a block read. The bytes are decoded into parallel control pins: skew polarity and bypass, step-skew codes, output drive strength, and a run/stop enable for each of ten differential output pairs.

A write frame carries the device address, then two header bytes (a command code and a byte count). The slave acknowledges both header bytes and discards their values. Data bytes follow, always stored from byte 0 upward. A read frame returns a byte count of 07h and then bytes 0 to 6. Three strap inputs are captured while reset is asserted and set the reset value of the fix-skew polarity bit and the two upper step-advance bits.

The serial lines are oversampled by the system clock. Each line passes through a two-flop synchronizer and a three-sample agreement filter. There is no streaming data path at the block's edge: the serial bus sets its own pace by clock stretching-free handshakes, so the control outputs are plain level pins with no valid/ready pairing.

Top module: `cfgslv_top`

## Requirements
- R1: The slave acknowledges only address byte D4h (write) or D5h (read), which is 7-bit address 6Ah. Any other address is NACKed, and the slave ignores every later byte until a stop.
- R2: In a write frame, the first two bytes after the address are acknowledged and have no effect on any register.
- R3: Write data bytes are stored in ascending order starting at byte 0. A stop after any complete byte keeps the bytes already stored. A repeated start makes the next write begin again at byte 0.
- R4: A stop that arrives before the 8th bit of a data byte leaves that byte unchanged.
- R5: A data byte sent after byte 6 is NACKed and changes nothing.
- R6: A read frame returns 07h first, then bytes 0 to 6 in order. Any byte requested after byte 6 reads as FFh.
- R7: While reset is asserted, the bytes load their defaults: byte0=FFh, byte1={pol,0,111111b}, byte2=00h, byte3={c1,0,c0,00000b}, byte4=00h, byte5=FFh, byte6=FFh. Here pol, c1 and c0 are the strap inputs. Straps have no effect after reset.
- R8: The output pins map onto the bytes as follows:
  - fix_pol_o is byte1 bit 7, and fix_bypass_o is byte1 bit 6.
  - drive_boost_o is byte2 bit 6.
  - step_adv_o is byte3, and step_dly_o is byte4.
  - For pair_run_o, bits [0..4] are byte5 bits 7..3, and bit [9] is byte5 bit 2.
  - pair_run_o bits [5..8] are byte6 bits 1..4.
- R9: sda_pull_o is low after reset. It changes only in response to a filtered SCL fall, a start or a stop.
- R10: The configuration outputs change only when a data byte completes, or during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset; straps are captured while it is low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | When high, the pad pulls SDA low |
| strap_pol_i | input | 1 | Reset value of the fix-skew polarity bit |
| strap_c1_i | input | 1 | Reset value of step-advance bit 7 |
| strap_c0_i | input | 1 | Reset value of step-advance bit 5 |
| fix_pol_o | output | 1 | Fix-skew polarity (0 advance, 1 delay) |
| fix_bypass_o | output | 1 | Fix-skew bypass (0 enabled, 1 bypassed) |
| drive_boost_o | output | 1 | Output drive strength (0 = 1x, 1 = 1.5x) |
| step_adv_o | output | 8 | Step-advance skew byte |
| step_dly_o | output | 8 | Step-delay skew byte |
| pair_run_o | output | 10 | Run (1) / stop (0) for each output pair |

## Verification
Four properties are checked on every cycle:
- SDA moves only after an SCL fall, a start or a stop.
- The write index never passes the last byte.
- A register write never targets an index beyond byte 6.
- The configuration outputs stay still in any cycle after one with no write.

Only the bench scenarios can show the protocol-level behaviour, because these depend on whole frames:
- Header bytes being discarded.
- The read sequence starting with 07h and ending in FFh.
- A mid-byte abort leaving the byte unchanged.
- A repeated start restarting at byte 0.
- The strap-dependent reset values.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;
  localparam int NREG = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WR,
    S_RD,
    S_IGN
  } bus_st_e;

  function automatic logic [7:0] cfg_default(input int unsigned idx, input logic pol,
                                             input logic c1, input logic c0);
    case (idx)
      1:       return {pol, 1'b0, 6'h3F};
      2:       return 8'h00;
      3:       return {c1, 1'b0, c0, 5'b00000};
      4:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgslv_line_filter.sv
module cfgslv_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;
  logic level_q, prev_q, level_d;

  always_comb begin
    if (&hist_q)      level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
    else              level_d = level_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      level_q <= 1'b1;
      prev_q  <= 1'b1;
    end else begin
      sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      level_q <= level_d;
      prev_q  <= level_q;
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~prev_q;
  assign fall_o  = ~level_q & prev_q;

  // R9: filtered edges are single-cycle pulses
  p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o));
endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank
  import cfgslv_pkg::*;
#(
  parameter int IDXW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 strap_pol_i,
  input  logic                 strap_c1_i,
  input  logic                 strap_c0_i,
  input  logic                 wr_en_i,
  input  logic [IDXW-1:0]      wr_idx_i,
  input  logic [7:0]           wr_data_i,
  input  logic [IDXW-1:0]      rd_idx_i,
  output logic [7:0]           rd_byte_o,
  output logic [NREG*8-1:0]    bytes_o
);
  logic [7:0] regs_q [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs_q[i] <= cfg_default(i, strap_pol_i, strap_c1_i, strap_c0_i);
    end else if (wr_en_i) begin
      for (int i = 0; i < NREG; i++)
        if (wr_idx_i == IDXW'(i)) regs_q[i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_byte_o = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx_i == IDXW'(i)) rd_byte_o = regs_q[i];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign bytes_o[g*8 +: 8] = regs_q[g];
  end

  // R10: contents hold unless a write arrives
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(bytes_o));
endmodule

// File: rtl/cfgslv_engine.sv
module cfgslv_engine
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6A,
  parameter int         IDXW     = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_lvl_i,
  input  logic            scl_rise_i,
  input  logic            scl_fall_i,
  input  logic            sda_lvl_i,
  input  logic            sda_rise_i,
  input  logic            sda_fall_i,
  input  logic [7:0]      rd_byte_i,
  output logic [IDXW-1:0] rd_idx_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [7:0]      wr_data_o,
  output logic            sda_pull_o
);
  localparam logic [IDXW-1:0] LAST  = IDXW'(NREG);
  localparam logic [IDXW-1:0] RSAT  = IDXW'(NREG + 1);
  localparam logic [7:0]      COUNT = 8'(NREG);

  bus_st_e         st_q;
  logic [3:0]      bitc_q;
  logic [7:0]      shreg_q, txsh_q, nxt_byte, tx_byte;
  logic            ack_q, hack_q, is_rd_q, pull_q, wr_en_q;
  logic [1:0]      hdr_q;
  logic [IDXW-1:0] widx_q, rpos_q, wr_idx_q;
  logic [7:0]      wr_data_q;
  logic            start_ev, stop_ev;

  assign start_ev = sda_fall_i & scl_lvl_i;
  assign stop_ev  = sda_rise_i & scl_lvl_i;
  assign nxt_byte = {shreg_q[6:0], sda_lvl_i};
  assign rd_idx_o = rpos_q - 1'b1;

  always_comb begin
    if (rpos_q == '0)       tx_byte = COUNT;
    else if (rpos_q <= LAST) tx_byte = rd_byte_i;
    else                    tx_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE; bitc_q <= '0; shreg_q <= '0; txsh_q <= '0;
      ack_q <= 1'b0; hack_q <= 1'b0; is_rd_q <= 1'b0; pull_q <= 1'b0;
      hdr_q <= '0; widx_q <= '0; rpos_q <= '0;
      wr_en_q <= 1'b0; wr_idx_q <= '0; wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_ev) begin
        st_q <= S_ADDR; bitc_q <= '0; pull_q <= 1'b0;
        hdr_q <= '0; widx_q <= '0; rpos_q <= '0;
      end else if (stop_ev) begin
        st_q <= S_IDLE; pull_q <= 1'b0;
      end else begin
        case (st_q)
          S_ADDR, S_WR: begin
            if (scl_rise_i && bitc_q < 4'd8) begin
              shreg_q <= nxt_byte;
              bitc_q  <= bitc_q + 4'd1;
              if (bitc_q == 4'd7) begin
                if (st_q == S_ADDR) begin
                  ack_q   <= (nxt_byte[7:1] == DEV_ADDR);
                  is_rd_q <= nxt_byte[0];
                end else if (hdr_q < 2'd2) begin
                  ack_q <= 1'b1;
                  hdr_q <= hdr_q + 2'd1;
                end else if (widx_q < LAST) begin
                  ack_q     <= 1'b1;
                  wr_en_q   <= 1'b1;
                  wr_idx_q  <= widx_q;
                  wr_data_q <= nxt_byte;
                  widx_q    <= widx_q + 1'b1;
                end else begin
                  ack_q <= 1'b0;
                end
              end
            end else if (scl_fall_i && bitc_q == 4'd8) begin
              pull_q <= ack_q;
              bitc_q <= 4'd9;
            end else if (scl_fall_i && bitc_q == 4'd9) begin
              pull_q <= 1'b0;
              bitc_q <= '0;
              if (st_q == S_ADDR) begin
                if (!ack_q) st_q <= S_IGN;
                else if (is_rd_q) begin
                  st_q   <= S_RD;
                  txsh_q <= tx_byte;
                  pull_q <= ~tx_byte[7];
                  rpos_q <= rpos_q + 1'b1;
                end else st_q <= S_WR;
              end
            end
          end
          S_RD: begin
            if (scl_rise_i && bitc_q < 4'd8) begin
              bitc_q <= bitc_q + 4'd1;
            end else if (scl_rise_i && bitc_q == 4'd9) begin
              hack_q <= ~sda_lvl_i;
            end else if (scl_fall_i && bitc_q >= 4'd1 && bitc_q <= 4'd7) begin
              txsh_q <= {txsh_q[6:0], 1'b1};
              pull_q <= ~txsh_q[6];
            end else if (scl_fall_i && bitc_q == 4'd8) begin
              pull_q <= 1'b0;
              bitc_q <= 4'd9;
            end else if (scl_fall_i && bitc_q == 4'd9) begin
              bitc_q <= '0;
              if (hack_q) begin
                txsh_q <= tx_byte;
                pull_q <= ~tx_byte[7];
                if (rpos_q != RSAT) rpos_q <= rpos_q + 1'b1;
              end else begin
                pull_q <= 1'b0;
                st_q   <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign wr_en_o    = wr_en_q;
  assign wr_idx_o   = wr_idx_q;
  assign wr_data_o  = wr_data_q;

  // R9: SDA drive moves only after an SCL fall, start or stop
  p_pull_on_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> $past(scl_fall_i || start_ev || stop_ev));
  // R1: no drive while idle or ignoring a foreign frame
  p_quiet_when_ignoring_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_IGN || st_q == S_IDLE) |-> !pull_q);
  // R5: write index saturates at the last byte
  p_widx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    widx_q <= LAST);
  // R5: no write ever targets an index past byte 6
  p_wr_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (wr_idx_o < LAST));
endmodule

// File: rtl/cfgslv_top.sv
module cfgslv_top
  import cfgslv_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h6A,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic       strap_pol_i,
  input  logic       strap_c1_i,
  input  logic       strap_c0_i,
  output logic       fix_pol_o,
  output logic       fix_bypass_o,
  output logic       drive_boost_o,
  output logic [7:0] step_adv_o,
  output logic [7:0] step_dly_o,
  output logic [9:0] pair_run_o
);
  localparam int IDXW = $clog2(NREG + 2);

  logic [1:0] line_raw, line_lvl, line_rise, line_fall;
  logic [IDXW-1:0] rd_idx, wr_idx;
  logic [7:0] rd_byte, wr_data;
  logic wr_en;
  logic [NREG*8-1:0] cfg;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    cfgslv_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .line_i(line_raw[g]),
      .level_o(line_lvl[g]), .rise_o(line_rise[g]), .fall_o(line_fall[g]));
  end

  cfgslv_engine #(.DEV_ADDR(DEV_ADDR), .IDXW(IDXW)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .scl_lvl_i(line_lvl[0]), .scl_rise_i(line_rise[0]), .scl_fall_i(line_fall[0]),
    .sda_lvl_i(line_lvl[1]), .sda_rise_i(line_rise[1]), .sda_fall_i(line_fall[1]),
    .rd_byte_i(rd_byte), .rd_idx_o(rd_idx),
    .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data),
    .sda_pull_o(sda_pull_o));

  cfgslv_regbank #(.IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .strap_pol_i(strap_pol_i), .strap_c1_i(strap_c1_i), .strap_c0_i(strap_c0_i),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .rd_idx_i(rd_idx), .rd_byte_o(rd_byte), .bytes_o(cfg));

  // R8: decode of the configuration bytes onto control pins
  assign fix_pol_o     = cfg[1*8 + 7];
  assign fix_bypass_o  = cfg[1*8 + 6];
  assign drive_boost_o = cfg[2*8 + 6];
  assign step_adv_o    = cfg[3*8 +: 8];
  assign step_dly_o    = cfg[4*8 +: 8];
  assign pair_run_o    = {cfg[5*8 + 2], cfg[6*8 + 4], cfg[6*8 + 3], cfg[6*8 + 2],
                          cfg[6*8 + 1], cfg[5*8 + 3], cfg[5*8 + 4], cfg[5*8 + 5],
                          cfg[5*8 + 6], cfg[5*8 + 7]};
endmodule

// File: tb/cfgslv_top_tb.sv
module cfgslv_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_scl = 1'b1, host_sda = 1'b1;
  logic strap_pol = 1'b1, strap_c1 = 1'b1, strap_c0 = 1'b0;
  logic sda_pull, fix_pol, fix_bypass, drive_boost;
  logic [7:0] step_adv, step_dly;
  logic [9:0] pair_run;
  logic bus_sda;
  int n_tests = 0, n_fail = 0;
  bit cmp_en = 1'b0, finished = 1'b0;
  logic [7:0] mdl [7];
  logic [7:0] fr [10];

  always #5 clk = ~clk;
  assign bus_sda = host_sda & ~sda_pull;

  cfgslv_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(host_scl), .sda_i(bus_sda), .sda_pull_o(sda_pull),
    .strap_pol_i(strap_pol), .strap_c1_i(strap_c1), .strap_c0_i(strap_c0),
    .fix_pol_o(fix_pol), .fix_bypass_o(fix_bypass), .drive_boost_o(drive_boost),
    .step_adv_o(step_adv), .step_dly_o(step_dly), .pair_run_o(pair_run));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [28:0] exp_pins();
    logic [9:0] pr;
    pr = {mdl[5][2], mdl[6][4], mdl[6][3], mdl[6][2], mdl[6][1],
          mdl[5][3], mdl[5][4], mdl[5][5], mdl[5][6], mdl[5][7]};
    return {mdl[1][7], mdl[1][6], mdl[2][6], mdl[3], mdl[4], pr};
  endfunction

  // R8 / R10: outputs compared with the model on every clock
  always @(negedge clk) begin
    if (cmp_en && rst_n)
      chk({fix_pol, fix_bypass, drive_boost, step_adv, step_dly, pair_run} == exp_pins(),
          "R8/R10 pins", {3'b0, fix_pol, fix_bypass, drive_boost, step_adv, step_dly, pair_run},
          {3'b0, exp_pins()});
  end

  task automatic wait_q();
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic p, input logic c1, input logic c0);
    cmp_en = 1'b0;
    strap_pol = p; strap_c1 = c1; strap_c0 = c0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mdl[0] = 8'hFF; mdl[1] = {p, 1'b0, 6'h3F}; mdl[2] = 8'h00;
    mdl[3] = {c1, 1'b0, c0, 5'b0}; mdl[4] = 8'h00; mdl[5] = 8'hFF; mdl[6] = 8'hFF;
    @(negedge clk);
    cmp_en = 1'b1;
    chk(sda_pull == 1'b0, "R9 reset idle", sda_pull, 0);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; host_scl = 1'b1; wait_q();
    host_sda = 1'b0; wait_q();
    host_scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wait_q();
    host_scl = 1'b1; wait_q();
    host_sda = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) cmp_en = 1'b0;
      host_sda = b[i]; wait_q();
      host_scl = 1'b1; wait_q(); wait_q();
      host_scl = 1'b0; wait_q();
    end
    host_sda = 1'b1; wait_q();
    host_scl = 1'b1; wait_q();
    acked = ~bus_sda; wait_q();
    host_scl = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] d);
    host_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_q(); host_scl = 1'b1; wait_q();
      d = {d[6:0], bus_sda};
      wait_q(); host_scl = 1'b0;
    end
    wait_q(); host_sda = ~ack; wait_q();
    host_scl = 1'b1; wait_q(); wait_q();
    host_scl = 1'b0; wait_q();
    host_sda = 1'b1;
  endtask

  // Write frame: address D4h, two header bytes, then n data bytes
  task automatic write_frame(input logic [7:0] d [10], input int n, input bit stop);
    logic a;
    int idx = 0;
    bus_start();
    send_byte(8'hD4, a); cmp_en = 1'b1;
    chk(a == 1'b1, "R1 write address ack", a, 1);
    send_byte(8'hA7, a); cmp_en = 1'b1;
    chk(a == 1'b1, "R2 command ack", a, 1);
    send_byte(8'h3C, a); cmp_en = 1'b1;
    chk(a == 1'b1, "R2 count ack", a, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(d[k], a);
      if (idx < 7) begin
        chk(a == 1'b1, "R3 data ack", a, 1);
        mdl[idx] = d[k];
        idx++;
      end else begin
        chk(a == 1'b0, "R5 overflow nack", a, 0);
      end
      cmp_en = 1'b1;
    end
    if (stop) bus_stop();
  endtask

  task automatic read_all();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hD5, a); cmp_en = 1'b1;
    chk(a == 1'b1, "R1 read address ack", a, 1);
    recv_byte(1'b1, d);
    chk(d == 8'h07, "R6 byte count", d, 8'h07);
    for (int i = 0; i < 7; i++) begin
      recv_byte(1'b1, d);
      chk(d == mdl[i], "R6 read data", d, mdl[i]);
    end
    recv_byte(1'b0, d);
    chk(d == 8'hFF, "R6 past end", d, 8'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=running exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic a;
    // R7: straps pol=1 c1=1 c0=0
    do_reset(1'b1, 1'b1, 1'b0);
    chk(step_adv == 8'h80, "R7 strap step byte", step_adv, 8'h80);
    chk(fix_pol == 1'b1, "R7 strap polarity", fix_pol, 1);
    strap_pol = 1'b0; strap_c1 = 1'b0; strap_c0 = 1'b1;
    wait_q();
    chk(fix_pol == 1'b1 && step_adv == 8'h80, "R7 straps ignored after reset",
        {fix_pol, step_adv}, {1'b1, 8'h80});
    read_all();

    // R3 / R5 / R2: full write plus one overflow byte
    fr[0] = 8'h12; fr[1] = 8'h34; fr[2] = 8'h40; fr[3] = 8'h5A;
    fr[4] = 8'hA5; fr[5] = 8'h00; fr[6] = 8'h00; fr[7] = 8'h77;
    write_frame(fr, 8, 1'b1);
    chk(pair_run == 10'h000, "R8 all pairs stopped", pair_run, 0);
    chk(drive_boost == 1'b1, "R8 drive boost", drive_boost, 1);
    read_all();

    // R3: short write keeps later bytes
    fr[0] = 8'hC3;
    write_frame(fr, 1, 1'b1);
    read_all();

    // R4: abort inside a data byte
    write_frame(fr, 0, 1'b0);
    for (int i = 0; i < 4; i++) begin
      host_sda = 1'b0; wait_q(); host_scl = 1'b1; wait_q(); wait_q(); host_scl = 1'b0; wait_q();
    end
    bus_stop();
    chk(step_adv == mdl[3], "R4 abort no change", step_adv, mdl[3]);
    read_all();

    // R1: foreign address ignored until stop
    bus_start();
    send_byte(8'hA0, a); cmp_en = 1'b1;
    chk(a == 1'b0, "R1 foreign address nack", a, 0);
    send_byte(8'h00, a); cmp_en = 1'b1;
    chk(a == 1'b0, "R1 ignored byte nack", a, 0);
    bus_stop();
    read_all();

    // R3: repeated start resets index
    fr[0] = 8'hEE; fr[1] = 8'hDD;
    write_frame(fr, 2, 1'b0);
    fr[0] = 8'h01;
    write_frame(fr, 1, 1'b1);
    chk(mdl[0] == 8'h01 && mdl[1] == 8'hDD, "R3 model restart", mdl[0], 8'h01);
    read_all();

    // R7: other strap values
    do_reset(1'b0, 1'b0, 1'b1);
    chk(step_adv == 8'h20 && fix_pol == 1'b0, "R7 second strap set", step_adv, 8'h20);
    chk(pair_run == 10'h3FF, "R7 pairs run at reset", pair_run, 10'h3FF);
    read_all();

    finished = 1'b1;
    cmp_en = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule